// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source layer and one processor thread. It holds the single interrupt currently offered to that processor. It merges two kinds of request: external sources arriving on a delivery input, and an internal inter-processor interrupt (IPI) whose urgency is set through its own priority register. Priorities are 8-bit values. Zero is the most urgent and 0xFF the least urgent.

The processor controls the block through four operations. It can set its current priority threshold. It can program the IPI priority. It can accept the pending interrupt, which reads the presentation word and moves the threshold up to that interrupt's priority. It can signal end-of-interrupt (EOI), which restores a threshold and passes the finished source number back to the source layer. Some sources cannot be held, either because they lose a priority comparison or because they are pushed out by a more urgent one. The block hands each such source back through a reject strobe. When the threshold is relaxed and nothing is pending, it asks the source layer to resend.

Top module: `ipres_core`

## Requirements
- R1: After reset, `pend_word` is 0 (threshold 0, no source) and `irq_o` and all strobes are low. The held pending priority and the IPI priority both reset to 0xFF.
- R2: `pend_word[31:24]` is the current threshold and `pend_word[23:0]` the pending source number. A source number of 0 means nothing is pending, and `irq_o` is high exactly when the source field is non-zero.
- R3: A delivery is rejected with its own source number if its priority is not below the threshold, or if a source is already pending at a priority numerically less than or equal to it. Otherwise it becomes the pending source and `irq_o` rises. Any source it displaces is rejected.
- R4: An IPI priority write stores the value. If the value is below the threshold, an IPI check runs. The check does nothing when a source is pending at a priority less than or equal to the IPI priority. Otherwise it rejects any displaced source and installs source number 2 at the IPI priority.
- R5: Accept returns the `pend_word` value present in its cycle. Afterwards the source field is 0, the threshold equals the former pending priority, the pending priority is 0xFF and `irq_o` is low.
- R6: EOI loads the threshold from `eoi_wdata[31:24]` and pulses `eoi_fwd_valid` with `eoi_wdata[23:0]`. If no source is pending, it also performs a resend (R8).
- R7: A threshold write to a more urgent (numerically lower) value rejects and clears a pending source whose priority is not below the new threshold. Otherwise the pending source is kept. No resend is requested.
- R8: A threshold write to an equal or less urgent value with nothing pending performs a resend. If the IPI priority is below the new threshold, an IPI check runs, and `resend_req` pulses.
- R9: Only one operation is taken per cycle, in the order accept, EOI, threshold write, IPI priority write, delivery. Lower-ranked requests in the same cycle are ignored.
- R10: State and strobes update on the clock edge that samples the operation. The strobes last one cycle, and an idle cycle leaves `pend_word` unchanged with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cppr_we | input | 1 | Threshold write request |
| cppr_wdata | input | 8 | New threshold |
| mfrr_we | input | 1 | IPI priority write request |
| mfrr_wdata | input | 8 | New IPI priority |
| ack_re | input | 1 | Accept the pending interrupt |
| eoi_we | input | 1 | End-of-interrupt request |
| eoi_wdata | input | 32 | Threshold in [31:24], finished source in [23:0] |
| dlv_valid | input | 1 | Delivery from the source layer |
| dlv_src | input | 24 | Delivered source number |
| dlv_prio | input | 8 | Delivered priority |
| pend_word | output | 32 | Presentation word; the accept read value |
| irq_o | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject strobe |
| rej_src | output | 24 | Rejected source number |
| eoi_fwd_valid | output | 1 | EOI forward strobe |
| eoi_fwd_src | output | 24 | Forwarded source number |
| resend_req | output | 1 | Resend request to the source layer |

## Verification
Deliveries are tried in several cases: below the threshold, equal to it, losing to a pending source of equal or better priority, and displacing a worse one. Together these separate the two rejection causes from a displacement reject. IPI priority writes are run against an empty presenter, a worse pending source and a better one, which distinguishes installation, displacement and no action. Threshold writes go both up and down, with and without a pending source, to show where a resend or a reject appears. A cycle with several simultaneous requests, followed by a resend, shows that the ignored IPI write left no trace.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ACCEPT,
    OP_EOI,
    OP_CPPR,
    OP_MFRR,
    OP_DLV
  } op_e;

  localparam int unsigned IPI_SRC_NUM = 2;

  // Fixed ranking of simultaneous requests (R9)
  function automatic op_e pick_op(input logic acc, input logic eoi,
                                  input logic thr, input logic ipi,
                                  input logic dlv);
    if (acc)      return OP_ACCEPT;
    else if (eoi) return OP_EOI;
    else if (thr) return OP_CPPR;
    else if (ipi) return OP_MFRR;
    else if (dlv) return OP_DLV;
    else          return OP_IDLE;
  endfunction

  // a is strictly more urgent than b
  function automatic logic more_urgent(input logic [7:0] a, input logic [7:0] b);
    return a < b;
  endfunction

endpackage

// File: rtl/ipres_op_sel.sv
module ipres_op_sel
  import ipres_pkg::*;
(
  input  logic ack_re,
  input  logic eoi_we,
  input  logic cppr_we,
  input  logic mfrr_we,
  input  logic dlv_valid,
  output op_e  op
);
  always_comb op = pick_op(ack_re, eoi_we, cppr_we, mfrr_we, dlv_valid);
endmodule

// File: rtl/ipres_ipi_chk.sv
module ipres_ipi_chk #(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input  logic              run,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic              fire,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_src
);
  logic busy, holds;
  always_comb begin
    busy    = (cur_src != '0);
    holds   = busy && (cur_prio <= ipi_prio);
    fire    = run && !holds;
    rej_v   = fire && busy;
    rej_src = cur_src;
  end
endmodule

// File: rtl/ipres_dlv_chk.sv
module ipres_dlv_chk #(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input  logic [SRC_W-1:0]  cur_src,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] thr,
  input  logic [SRC_W-1:0]  new_src,
  input  logic [PRIO_W-1:0] new_prio,
  output logic              take,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_src
);
  logic busy, beats_thr, loses;
  always_comb begin
    busy      = (cur_src != '0);
    beats_thr = new_prio < thr;
    loses     = busy && (cur_prio <= new_prio);
    take      = beats_thr && !loses;
    rej_v     = !take || busy;
    rej_src   = take ? cur_src : new_src;
  end
endmodule

// File: rtl/ipres_core.sv
module ipres_core
  import ipres_pkg::*;
#(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cppr_we,
  input  logic [PRIO_W-1:0]       cppr_wdata,
  input  logic                    mfrr_we,
  input  logic [PRIO_W-1:0]       mfrr_wdata,
  input  logic                    ack_re,
  input  logic                    eoi_we,
  input  logic [PRIO_W+SRC_W-1:0] eoi_wdata,
  input  logic                    dlv_valid,
  input  logic [SRC_W-1:0]        dlv_src,
  input  logic [PRIO_W-1:0]       dlv_prio,
  output logic [PRIO_W+SRC_W-1:0] pend_word,
  output logic                    irq_o,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_fwd_valid,
  output logic [SRC_W-1:0]        eoi_fwd_src,
  output logic                    resend_req
);
  localparam int unsigned WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI_SRC    = SRC_W'(IPI_SRC_NUM);

  logic [PRIO_W-1:0] thr_q, pprio_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic              irq_q;
  logic              rej_q, eoi_q, rs_q;
  logic [SRC_W-1:0]  rejsrc_q, eoisrc_q;

  logic [PRIO_W-1:0] thr_n, pprio_n, ipi_n;
  logic [SRC_W-1:0]  src_n, rejsrc_n, eoisrc_n;
  logic              irq_n, rej_n, eoi_n, rs_n;

  // named internal events
  op_e               op;
  logic              resend_go;
  logic              thr_tighten;
  logic              ipi_run, ipi_fire, ipi_rej;
  logic [SRC_W-1:0]  ipi_rej_src;
  logic [PRIO_W-1:0] ipi_prio_eff, thr_eff;
  logic              dlv_take, dlv_rej;
  logic [SRC_W-1:0]  dlv_rej_src;
  logic [PRIO_W-1:0] eoi_thr;
  logic [SRC_W-1:0]  eoi_src;

  assign eoi_thr = eoi_wdata[WORD_W-1:SRC_W];
  assign eoi_src = eoi_wdata[SRC_W-1:0];

  ipres_op_sel u_sel (
    .ack_re   (ack_re),
    .eoi_we   (eoi_we),
    .cppr_we  (cppr_we),
    .mfrr_we  (mfrr_we),
    .dlv_valid(dlv_valid),
    .op       (op)
  );

  always_comb begin
    thr_tighten  = (cppr_wdata < thr_q);
    resend_go    = (src_q == '0) &&
                   ((op == OP_EOI) || ((op == OP_CPPR) && !thr_tighten));
    ipi_prio_eff = (op == OP_MFRR) ? mfrr_wdata : ipi_q;
    case (op)
      OP_CPPR: thr_eff = cppr_wdata;
      OP_EOI:  thr_eff = eoi_thr;
      default: thr_eff = thr_q;
    endcase
    ipi_run = ((op == OP_MFRR) || resend_go) && (ipi_prio_eff < thr_eff);
  end

  ipres_ipi_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi (
    .run     (ipi_run),
    .cur_src (src_q),
    .cur_prio(pprio_q),
    .ipi_prio(ipi_prio_eff),
    .fire    (ipi_fire),
    .rej_v   (ipi_rej),
    .rej_src (ipi_rej_src)
  );

  ipres_dlv_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_dlv (
    .cur_src (src_q),
    .cur_prio(pprio_q),
    .thr     (thr_q),
    .new_src (dlv_src),
    .new_prio(dlv_prio),
    .take    (dlv_take),
    .rej_v   (dlv_rej),
    .rej_src (dlv_rej_src)
  );

  always_comb begin
    thr_n    = thr_q;
    src_n    = src_q;
    pprio_n  = pprio_q;
    ipi_n    = ipi_q;
    irq_n    = irq_q;
    rej_n    = 1'b0;
    rejsrc_n = '0;
    eoi_n    = 1'b0;
    eoisrc_n = '0;
    rs_n     = 1'b0;
    case (op)
      OP_ACCEPT: begin
        src_n   = '0;
        thr_n   = pprio_q;
        pprio_n = PRIO_LEAST;
        irq_n   = 1'b0;
      end
      OP_EOI: begin
        thr_n    = eoi_thr;
        eoi_n    = 1'b1;
        eoisrc_n = eoi_src;
        rs_n     = resend_go;
      end
      OP_CPPR: begin
        thr_n = cppr_wdata;
        rs_n  = resend_go;
        if (thr_tighten && (src_q != '0) && (cppr_wdata <= pprio_q)) begin
          rej_n    = 1'b1;
          rejsrc_n = src_q;
          src_n    = '0;
          pprio_n  = PRIO_LEAST;
          irq_n    = 1'b0;
        end
      end
      OP_MFRR: ipi_n = mfrr_wdata;
      OP_DLV: begin
        rej_n    = dlv_rej;
        rejsrc_n = dlv_rej_src;
        if (dlv_take) begin
          src_n   = dlv_src;
          pprio_n = dlv_prio;
          irq_n   = 1'b1;
        end
      end
      default: ;
    endcase
    if (ipi_fire) begin
      src_n   = IPI_SRC;
      pprio_n = ipi_prio_eff;
      irq_n   = 1'b1;
      if (ipi_rej) begin
        rej_n    = 1'b1;
        rejsrc_n = ipi_rej_src;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q    <= '0;
      src_q    <= '0;
      pprio_q  <= PRIO_LEAST;
      ipi_q    <= PRIO_LEAST;
      irq_q    <= 1'b0;
      rej_q    <= 1'b0;
      rejsrc_q <= '0;
      eoi_q    <= 1'b0;
      eoisrc_q <= '0;
      rs_q     <= 1'b0;
    end else begin
      thr_q    <= thr_n;
      src_q    <= src_n;
      pprio_q  <= pprio_n;
      ipi_q    <= ipi_n;
      irq_q    <= irq_n;
      rej_q    <= rej_n;
      rejsrc_q <= rejsrc_n;
      eoi_q    <= eoi_n;
      eoisrc_q <= eoisrc_n;
      rs_q     <= rs_n;
    end
  end

  assign pend_word     = {thr_q, src_q};
  assign irq_o         = irq_q;
  assign rej_valid     = rej_q;
  assign rej_src       = rejsrc_q;
  assign eoi_fwd_valid = eoi_q;
  assign eoi_fwd_src   = eoisrc_q;
  assign resend_req    = rs_q;

endmodule

// File: rtl/ipres_checker.sv
module ipres_checker #(
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cppr_we,
  input logic                    mfrr_we,
  input logic                    ack_re,
  input logic                    eoi_we,
  input logic [PRIO_W+SRC_W-1:0] eoi_wdata,
  input logic                    dlv_valid,
  input logic [SRC_W-1:0]        dlv_src,
  input logic [PRIO_W-1:0]       dlv_prio,
  input logic [PRIO_W+SRC_W-1:0] pend_word,
  input logic                    irq_o,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_fwd_valid,
  input logic [SRC_W-1:0]        eoi_fwd_src,
  input logic                    resend_req
);
  localparam int unsigned WORD_W = PRIO_W + SRC_W;

  logic any_op, dlv_only, eoi_taken;
  assign any_op    = cppr_we | mfrr_we | ack_re | eoi_we | dlv_valid;
  assign dlv_only  = dlv_valid & ~(cppr_we | mfrr_we | ack_re | eoi_we);
  assign eoi_taken = eoi_we & ~ack_re;

  AST_IRQ_TRACKS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_word[SRC_W-1:0] != '0)); // R2

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_re |=> (pend_word[SRC_W-1:0] == '0) && !irq_o); // R5

  AST_EOI_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_taken |=> eoi_fwd_valid && (eoi_fwd_src == $past(eoi_wdata[SRC_W-1:0]))
                  && (pend_word[WORD_W-1:SRC_W] == $past(eoi_wdata[WORD_W-1:SRC_W]))); // R6

  AST_WEAK_DLV_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_only && (dlv_prio >= pend_word[WORD_W-1:SRC_W]))
      |=> rej_valid && (rej_src == $past(dlv_src)) && $stable(pend_word)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |=> $stable(pend_word) && !rej_valid && !eoi_fwd_valid && !resend_req); // R10

  AST_EOI_ONLY_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_taken |=> !eoi_fwd_valid); // R9

endmodule

bind ipres_core ipres_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) i_ipres_checker (.*);

// File: tb/test_ipres_core.sv
module test_ipres_core;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 131;
  localparam int NV = 22;

  // {req, op, data, prio, word, irq, rej, rejsrc, eoi, eoisrc, resend}
  // op: 0 idle, 1 threshold, 2 IPI prio, 3 accept, 4 EOI, 5 delivery
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd3, 3'd5, 32'h30,       8'h05, 32'h00000000, 1'b0, 1'b1, 24'h30, 1'b0, 24'h0,  1'b0}, // R3 thr 0 blocks all
    {4'd8, 3'd1, 32'hFF,       8'h00, 32'hFF000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1}, // R8
    {4'd3, 3'd5, 32'h30,       8'h05, 32'hFF000030, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R3 taken
    {4'd3, 3'd5, 32'h31,       8'h07, 32'hFF000030, 1'b1, 1'b1, 24'h31, 1'b0, 24'h0,  1'b0}, // R3 loses
    {4'd3, 3'd5, 32'h32,       8'h03, 32'hFF000032, 1'b1, 1'b1, 24'h30, 1'b0, 24'h0,  1'b0}, // R3 displaces
    {4'd5, 3'd3, 32'h0,        8'h00, 32'h03000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R5
    {4'd3, 3'd5, 32'h40,       8'h03, 32'h03000000, 1'b0, 1'b1, 24'h40, 1'b0, 24'h0,  1'b0}, // R3 equal thr
    {4'd6, 3'd4, 32'hFF000032, 8'h00, 32'hFF000000, 1'b0, 1'b0, 24'h0,  1'b1, 24'h32, 1'b1}, // R6
    {4'd4, 3'd2, 32'h10,       8'h00, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R4 install
    {4'd3, 3'd5, 32'h50,       8'h08, 32'hFF000050, 1'b1, 1'b1, 24'h02, 1'b0, 24'h0,  1'b0}, // R3 beats IPI
    {4'd4, 3'd2, 32'h04,       8'h00, 32'hFF000002, 1'b1, 1'b1, 24'h50, 1'b0, 24'h0,  1'b0}, // R4 displaces
    {4'd4, 3'd2, 32'h06,       8'h00, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R4 no action
    {4'd7, 3'd1, 32'h02,       8'h00, 32'h02000000, 1'b0, 1'b1, 24'h02, 1'b0, 24'h0,  1'b0}, // R7 clears
    {4'd8, 3'd1, 32'h08,       8'h00, 32'h08000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1}, // R8 with IPI
    {4'd5, 3'd3, 32'h0,        8'h00, 32'h06000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R5
    {4'd6, 3'd4, 32'hFF000002, 8'h00, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b1, 24'h02, 1'b1}, // R6 resend IPI
    {4'd7, 3'd1, 32'h06,       8'h00, 32'h06000000, 1'b0, 1'b1, 24'h02, 1'b0, 24'h0,  1'b0}, // R7 equal
    {4'd10,3'd0, 32'h0,        8'h00, 32'h06000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R10 idle
    {4'd7, 3'd1, 32'h05,       8'h00, 32'h05000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R7 no resend
    {4'd8, 3'd1, 32'hFF,       8'h00, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1}, // R8
    {4'd7, 3'd1, 32'h07,       8'h00, 32'h07000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0}, // R7 keeps
    {4'd3, 3'd5, 32'h60,       8'h06, 32'h07000002, 1'b1, 1'b1, 24'h60, 1'b0, 24'h0,  1'b0}  // R3 equal pending
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cppr_we = 1'b0, mfrr_we = 1'b0, ack_re = 1'b0, eoi_we = 1'b0, dlv_valid = 1'b0;
  logic [7:0]  cppr_wdata = '0, mfrr_wdata = '0, dlv_prio = '0;
  logic [31:0] eoi_wdata = '0;
  logic [23:0] dlv_src = '0;
  logic [31:0] pend_word;
  logic        irq_o, rej_valid, eoi_fwd_valid, resend_req;
  logic [23:0] rej_src, eoi_fwd_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipres_core i_ipres_core (
    .clk(clk), .rst_n(rst_n),
    .cppr_we(cppr_we), .cppr_wdata(cppr_wdata),
    .mfrr_we(mfrr_we), .mfrr_wdata(mfrr_wdata),
    .ack_re(ack_re), .eoi_we(eoi_we), .eoi_wdata(eoi_wdata),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
    .pend_word(pend_word), .irq_o(irq_o),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_fwd_valid(eoi_fwd_valid), .eoi_fwd_src(eoi_fwd_src),
    .resend_req(resend_req)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    cppr_we = 0; mfrr_we = 0; ack_re = 0; eoi_we = 0; dlv_valid = 0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] d, input logic [7:0] p);
    case (op)
      3'd1: begin cppr_we = 1; cppr_wdata = d[7:0]; end
      3'd2: begin mfrr_we = 1; mfrr_wdata = d[7:0]; end
      3'd3: ack_re = 1;
      3'd4: begin eoi_we = 1; eoi_wdata = d; end
      3'd5: begin dlv_valid = 1; dlv_src = d[23:0]; dlv_prio = p; end
      default: ;
    endcase
  endtask

  task automatic expect_all(input int req, input logic [31:0] w, input logic irq,
                            input logic rj, input logic [23:0] rjs,
                            input logic eo, input logic [23:0] eos, input logic rs);
    check(req, "pend_word", pend_word, w);
    check(req, "irq_o", {31'b0, irq_o}, {31'b0, irq});
    check(req, "rej_valid", {31'b0, rej_valid}, {31'b0, rj});
    if (rj) check(req, "rej_src", {8'b0, rej_src}, {8'b0, rjs});
    check(req, "eoi_fwd_valid", {31'b0, eoi_fwd_valid}, {31'b0, eo});
    if (eo) check(req, "eoi_fwd_src", {8'b0, eoi_fwd_src}, {8'b0, eos});
    check(req, "resend_req", {31'b0, resend_req}, {31'b0, rs});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_all(1, 32'h0, 0, 0, 0, 0, 0, 0); // R1 reset state

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      if (v[126:124] == 3'd3)  // R5: accept returns current word
        check(5, "accept read value", pend_word, (i == 5) ? 32'hFF000032 : 32'h08000002);
      drive(v[126:124], v[123:92], v[91:84]);
      @(negedge clk);
      clear_inputs();
      expect_all(int'(v[130:127]), v[83:52], v[51], v[50], v[49:26], v[25], v[24:1], v[0]);
    end

    // R9: accept outranks IPI write and delivery in the same cycle
    ack_re = 1; mfrr_we = 1; mfrr_wdata = 8'hFF; dlv_valid = 1; dlv_src = 24'h70; dlv_prio = 8'h00;
    @(negedge clk);
    clear_inputs();
    expect_all(9, 32'h06000000, 0, 0, 0, 0, 0, 0);
    // IPI priority must still be 6: relaxing the threshold re-installs the IPI
    cppr_we = 1; cppr_wdata = 8'hFF;
    @(negedge clk);
    clear_inputs();
    expect_all(9, 32'hFF000002, 1, 0, 0, 0, 0, 1);

    // R1: reset mid-run, then show both priorities returned to 0xFF
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_all(1, 32'h0, 0, 0, 0, 0, 0, 0);
    cppr_we = 1; cppr_wdata = 8'hFF;
    @(negedge clk);
    clear_inputs();
    expect_all(1, 32'hFF000000, 0, 0, 0, 0, 0, 1); // no IPI: its priority is 0xFF
    ack_re = 1;
    @(negedge clk);
    clear_inputs();
    expect_all(1, 32'hFF000000, 0, 0, 0, 0, 0, 0); // threshold from pending prio 0xFF

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule